// File: doc/BRIEF.md
# M-of-N Delay-Insensitive Codec

This block converts between binary symbol indices and N-rail delay-insensitive signals in which a data symbol is any pattern with exactly M rails high. The all-low pattern is the spacer that must separate successive data symbols. The encoder half takes a phase select (spacer or data) and a symbol index, and drives the N rails. When the index is too large for the code, it drives the spacer and raises a range error.

The decoder half watches N incoming rails and reports four things: whether the rails form a spacer, whether a complete codeword is present, which index that codeword carries, and whether more than M rails are high. It also raises a protocol error when one complete codeword is replaced by a different one without an all-low pattern in between. Both halves sample on a clock, so this is a synchronous model of the codec. It can sit beside asynchronous-style logic under simulation, or serve as a reference for dense M-hot signalling.

Codewords are numbered in ascending numeric order of the rail vector. For N=4 and M=2 there are six codewords. In rail-3-to-rail-0 order they are 0011, 0101, 0110, 1001, 1010 and 1100, and they carry indices 0 to 5.

Top module: `mofn_codec`

## Requirements
- R1: When enc_phase_data is 0, enc_rails is all zeros one clock later and enc_range_err is 0, whatever enc_index holds.
- R2: When enc_phase_data is 1 and enc_index < C(N,M), enc_rails one clock later equals the codeword of that index. Codeword k is the k-th smallest N-bit vector with exactly M bits set (for N=4, M=2: index 0 is 0011, index 5 is 1100, bit 0 = rail 0).
- R3: When enc_phase_data is 1 and enc_index >= C(N,M), enc_rails is all zeros and enc_range_err is 1 one clock later.
- R4: dec_spacer is 1 one clock after dec_rails is all zeros, and 0 one clock after any other pattern.
- R5: When exactly M rails of dec_rails are high, dec_complete is 1 one clock later and dec_index holds the index of that codeword under the R2 ordering.
- R6: A partial symbol, with 1 to M-1 rails high, gives dec_complete 0, dec_spacer 0 and dec_illegal 0.
- R7: When more than M rails are high, dec_illegal is 1 and dec_complete is 0 one clock later.
- R8: dec_index reads zero in every cycle where dec_complete is 0.
- R9: dec_proto_err pulses for one clock, together with dec_complete, when a complete codeword follows a different complete codeword and no all-zero pattern came between them. Partial and illegal patterns in between do not clear this history. A repeated identical codeword does not raise the error.
- R10: All outputs are registered with one clock of latency. While rst_n is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_phase_data | input | 1 | 1 = emit data codeword, 0 = emit spacer |
| enc_index | input | IW | Symbol index to encode (IW = clog2 of C(N,M), at least 1) |
| enc_rails | output | N | Encoded rails |
| enc_range_err | output | 1 | Index out of range in data phase |
| dec_rails | input | N | Incoming rails to decode |
| dec_spacer | output | 1 | Rails were all low |
| dec_complete | output | 1 | Rails held a full codeword |
| dec_index | output | IW | Recovered index, zero unless complete |
| dec_illegal | output | 1 | More than M rails were high |
| dec_proto_err | output | 1 | Codeword changed without an intervening spacer |

## Verification
The assertions assume that every rail pattern arrives as a whole vector in one sampled cycle. They also assume that enc_index is meaningful only when the data phase is selected, so they check its range against the error flag alone. The stimulus is built to respect this. It enumerates every index in range, walks every proper nonzero subset of each codeword as a partial arrival, covers every vector of weight above M, and tries out-of-range indices in both phases. It also runs a short sequence of codeword-to-codeword changes, with and without spacers and partials between them, to exercise the spacer history.

// File: rtl/mofn_pkg.sv
package mofn_pkg;

    localparam int MAX_RAILS = 8;

    function automatic int binom(input int n, input int k);
        int r;
        r = 1;
        if (k < 0 || k > n) return 0;
        for (int i = 1; i <= k; i++) r = (r * (n - k + i)) / i;
        return r;
    endfunction

    function automatic int popcnt(input int v, input int n);
        int c;
        c = 0;
        for (int b = 0; b < n; b++) c += (v >> b) & 1;
        return c;
    endfunction

    // k-th smallest n-bit vector carrying exactly m ones
    function automatic logic [MAX_RAILS-1:0] nth_word(input int n, input int m, input int k);
        int seen;
        seen = 0;
        for (int v = 0; v < (1 << n); v++) begin
            if (popcnt(v, n) == m) begin
                if (seen == k) return MAX_RAILS'(v);
                seen++;
            end
        end
        return '0;
    endfunction

endpackage

// File: rtl/mofn_weight.sv
module mofn_weight #(
    parameter int N  = 4,
    parameter int WW = $clog2(N + 1)
) (
    input  logic [N-1:0]  rails,
    output logic [WW-1:0] weight
);
    always_comb begin
        weight = '0;
        for (int b = 0; b < N; b++) weight = weight + WW'(rails[b]);
    end
endmodule

// File: rtl/mofn_encoder.sv
module mofn_encoder #(
    parameter int N    = 4,
    parameter int M    = 2,
    parameter int NSYM = mofn_pkg::binom(N, M),
    parameter int IW   = (NSYM > 1) ? $clog2(NSYM) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          phase_data,
    input  logic [IW-1:0] index,
    output logic [N-1:0]  rails,
    output logic          range_err
);
    typedef struct packed {
        logic [N-1:0] rails;
        logic         err;
    } enc_state_t;

    logic [N-1:0] cw_tab [NSYM];
    enc_state_t   st_d, st_q;

    for (genvar g = 0; g < NSYM; g++) begin : g_tab
        localparam logic [mofn_pkg::MAX_RAILS-1:0] WORD = mofn_pkg::nth_word(N, M, g);
        assign cw_tab[g] = WORD[N-1:0];
    end

    always_comb begin
        st_d = '0;
        if (phase_data) begin
            if (int'(index) >= NSYM) begin
                st_d.err = 1'b1;
            end else begin
                for (int i = 0; i < NSYM; i++) begin
                    if (index == IW'(i)) st_d.rails = cw_tab[i];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rails     = st_q.rails;
    assign range_err = st_q.err;
endmodule

// File: rtl/mofn_decoder.sv
module mofn_decoder #(
    parameter int N    = 4,
    parameter int M    = 2,
    parameter int NSYM = mofn_pkg::binom(N, M),
    parameter int IW   = (NSYM > 1) ? $clog2(NSYM) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  rails,
    output logic          spacer,
    output logic          complete,
    output logic [IW-1:0] index,
    output logic          illegal,
    output logic          proto_err
);
    localparam int WW = $clog2(N + 1);

    typedef struct packed {
        logic          spacer;
        logic          complete;
        logic [IW-1:0] index;
        logic          illegal;
        logic          proto;
        logic [N-1:0]  held;
        logic          held_vld;
    } dec_state_t;

    logic [N-1:0]  cw_tab [NSYM];
    logic [WW-1:0] weight;
    logic          hit;
    logic [IW-1:0] hit_idx;
    dec_state_t    st_d, st_q;

    for (genvar g = 0; g < NSYM; g++) begin : g_tab
        localparam logic [mofn_pkg::MAX_RAILS-1:0] WORD = mofn_pkg::nth_word(N, M, g);
        assign cw_tab[g] = WORD[N-1:0];
    end

    mofn_weight #(.N(N), .WW(WW)) u_weight (
        .rails  (rails),
        .weight (weight)
    );

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = 0; i < NSYM; i++) begin
            if (rails == cw_tab[i]) begin
                hit     = 1'b1;
                hit_idx = hit_idx | IW'(i);
            end
        end
    end

    always_comb begin
        st_d          = st_q;
        st_d.spacer   = (rails == '0);
        st_d.illegal  = (int'(weight) > M);
        st_d.complete = hit && (int'(weight) == M);
        st_d.index    = st_d.complete ? hit_idx : '0;
        st_d.proto    = st_d.complete && st_q.held_vld && (rails != st_q.held);
        if (st_d.spacer) begin
            st_d.held_vld = 1'b0;
        end else if (st_d.complete) begin
            st_d.held     = rails;
            st_d.held_vld = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign spacer    = st_q.spacer;
    assign complete  = st_q.complete;
    assign index     = st_q.index;
    assign illegal   = st_q.illegal;
    assign proto_err = st_q.proto;
endmodule

// File: rtl/mofn_codec.sv
module mofn_codec #(
    parameter int N = 4,
    parameter int M = 2,
    localparam int NSYM = mofn_pkg::binom(N, M),
    localparam int IW   = (NSYM > 1) ? $clog2(NSYM) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enc_phase_data,
    input  logic [IW-1:0] enc_index,
    output logic [N-1:0]  enc_rails,
    output logic          enc_range_err,
    input  logic [N-1:0]  dec_rails,
    output logic          dec_spacer,
    output logic          dec_complete,
    output logic [IW-1:0] dec_index,
    output logic          dec_illegal,
    output logic          dec_proto_err
);
    if (M < 1 || M >= N || N > mofn_pkg::MAX_RAILS) begin : g_bad_params
        initial $fatal(1, "mofn_codec: need 1 <= M < N <= 8");
    end

    mofn_encoder #(.N(N), .M(M), .NSYM(NSYM), .IW(IW)) u_enc (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_data (enc_phase_data),
        .index      (enc_index),
        .rails      (enc_rails),
        .range_err  (enc_range_err)
    );

    mofn_decoder #(.N(N), .M(M), .NSYM(NSYM), .IW(IW)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .rails     (dec_rails),
        .spacer    (dec_spacer),
        .complete  (dec_complete),
        .index     (dec_index),
        .illegal   (dec_illegal),
        .proto_err (dec_proto_err)
    );
endmodule

// File: rtl/mofn_codec_chk.sv
module mofn_codec_chk #(
    parameter int N    = 4,
    parameter int M    = 2,
    parameter int NSYM = 6,
    parameter int IW   = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enc_phase_data,
    input logic [IW-1:0] enc_index,
    input logic [N-1:0]  enc_rails,
    input logic          enc_range_err,
    input logic [N-1:0]  dec_rails,
    input logic          dec_spacer,
    input logic          dec_complete,
    input logic [IW-1:0] dec_index,
    input logic          dec_illegal,
    input logic          dec_proto_err
);
    // R1
    spacer_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enc_phase_data) |-> enc_rails == '0);

    // R2
    enc_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(enc_rails) == 0) || ($countones(enc_rails) == M));

    // R3
    range_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enc_range_err |-> (enc_rails == '0) && (int'($past(enc_index)) >= NSYM));

    // R4
    dec_spacer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_spacer |-> $past(dec_rails) == '0);

    // R5
    complete_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_complete |-> $countones($past(dec_rails)) == M);

    // R7
    illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_illegal |-> !dec_complete && ($countones($past(dec_rails)) > M));

    // R8
    idle_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_complete |-> dec_index == '0);

    // R9
    proto_with_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_proto_err |-> dec_complete && !dec_spacer);
endmodule

bind mofn_codec mofn_codec_chk #(.N(N), .M(M), .NSYM(NSYM), .IW(IW)) u_chk (.*);

// File: tb/mofn_codec_test.sv
`timescale 1ns/1ps
module mofn_codec_test;
    localparam int N    = 4;
    localparam int M    = 2;
    localparam int NSYM = mofn_pkg::binom(N, M);
    localparam int IW   = (NSYM > 1) ? $clog2(NSYM) : 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enc_phase_data = 1'b0;
    logic [IW-1:0] enc_index = '0;
    logic [N-1:0]  enc_rails;
    logic          enc_range_err;
    logic [N-1:0]  dec_rails = '0;
    logic          dec_spacer, dec_complete, dec_illegal, dec_proto_err;
    logic [IW-1:0] dec_index;

    always #5 clk = ~clk;

    mofn_codec #(.N(N), .M(M)) uut (.*);

    typedef struct {
        int    rails;
        int    err;
        int    sp;
        int    cm;
        int    ix;
        int    il;
        int    pe;
        string etag;
        string dtag;
    } exp_t;

    exp_t q[$];
    int   ref_cw [256];
    int   tests = 0;
    int   fails = 0;
    bit   done = 0;
    int   m_held = 0;
    bit   m_vld = 0;

    task automatic check(input string tag, input string field, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, field, act, exp);
        end
    endtask

    // driver: set inputs at a falling edge, queue what must appear after the next rising edge
    task automatic step(input bit ph, input int idx, input int drv, input string etag, input string dtag);
        exp_t e;
        int   w;
        @(negedge clk);
        enc_phase_data = ph;
        enc_index      = IW'(idx);
        dec_rails      = N'(drv);
        e.etag  = etag;
        e.dtag  = dtag;
        e.err   = (ph && idx >= NSYM) ? 1 : 0;
        e.rails = (ph && idx < NSYM) ? ref_cw[idx] : 0;
        w       = $countones(N'(drv));
        e.sp    = (drv == 0) ? 1 : 0;
        e.il    = (w > M) ? 1 : 0;
        e.cm    = (w == M) ? 1 : 0;
        e.ix    = 0;
        if (e.cm == 1) begin
            for (int k = 0; k < NSYM; k++) if (ref_cw[k] == drv) e.ix = k;
        end
        e.pe = (e.cm == 1 && m_vld && m_held != drv) ? 1 : 0;
        if (drv == 0) m_vld = 0;
        else if (e.cm == 1) begin
            m_held = drv;
            m_vld  = 1;
        end
        q.push_back(e);
    endtask

    // monitor: compare just after each rising edge
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(e.etag, "enc_rails", int'(enc_rails), e.rails);
            check("R3", "enc_range_err", int'(enc_range_err), e.err);
            check("R4", "dec_spacer", int'(dec_spacer), e.sp);
            check(e.dtag, "dec_complete", int'(dec_complete), e.cm);
            check(e.cm ? "R5" : "R8", "dec_index", int'(dec_index), e.ix);
            check("R7", "dec_illegal", int'(dec_illegal), e.il);
            check("R9", "dec_proto_err", int'(dec_proto_err), e.pe);
        end
    end

    initial begin
        int n;
        n = 0;
        for (int v = 0; v < (1 << N); v++) begin
            if ($countones(N'(v)) == M) begin
                ref_cw[n] = v;
                n++;
            end
        end

        // R10: reset state
        enc_phase_data = 1'b1;
        dec_rails      = '1;
        repeat (3) @(negedge clk);
        check("R10", "reset outputs",
              int'({enc_rails, enc_range_err, dec_spacer, dec_complete, dec_index, dec_illegal, dec_proto_err}), 0);
        enc_phase_data = 1'b0;
        dec_rails      = '0;
        @(negedge clk);
        rst_n = 1'b1;

        // R1: spacer phase ignores index
        step(1'b0, 0, 0, "R1", "R4");
        step(1'b0, NSYM - 1, 0, "R1", "R4");

        // R2 / R5: every index, each followed by a spacer
        for (int k = 0; k < NSYM; k++) begin
            step(1'b1, k, ref_cw[k], "R2", "R5");
            step(1'b0, k, 0, "R1", "R4");
        end

        // R6: every partial subset of every codeword
        for (int k = 0; k < NSYM; k++) begin
            for (int s = 1; s < ref_cw[k]; s++) begin
                if ((s & ~ref_cw[k]) == 0) begin
                    step(1'b0, 0, s, "R1", "R6");
                    step(1'b0, 0, 0, "R1", "R4");
                end
            end
        end

        // R7: every over-weight vector
        for (int v = 0; v < (1 << N); v++) begin
            if ($countones(N'(v)) > M) step(1'b0, 0, v, "R1", "R7");
        end
        step(1'b0, 0, 0, "R1", "R4");

        // R3: out-of-range indices in both phases
        for (int i = NSYM; i < (1 << IW); i++) begin
            step(1'b1, i, 0, "R3", "R4");
            step(1'b0, i, 0, "R1", "R4");
        end

        // R9: codeword changes
        step(1'b0, 0, ref_cw[0], "R1", "R9");
        step(1'b0, 0, ref_cw[1], "R1", "R9");
        step(1'b0, 0, ref_cw[1], "R1", "R9");
        step(1'b0, 0, 0, "R1", "R4");
        step(1'b0, 0, ref_cw[2], "R1", "R9");
        step(1'b0, 0, ref_cw[2] & (ref_cw[2] - 1), "R1", "R6");
        step(1'b0, 0, '1, "R1", "R7");
        step(1'b0, 0, ref_cw[NSYM-1], "R1", "R9");
        step(1'b0, 0, 0, "R1", "R4");

        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule